// File: doc/BRIEF.md
# Trace Message Buffer with Selectable Full Policy

This block sits between a trace message source and a trace output port that is narrower than the source's peak rate. Trace messages arrive in irregular bursts, one per cycle at most. Each message carries a class tag: program flow, data access or instrumentation. The block stores the messages in arrival order in a first-in first-out buffer of parameterised depth. The output side presents the oldest stored message and removes it in any cycle where the port signals it is ready.

A two-bit policy input chooses what happens when the buffer has no room for a new message.

- **Halt policy:** tracing stops and a sticky overflow flag rises. Only a clear pulse from software lowers the flag.
- **Suppress policy:** the block drops data-class messages once the buffer has filled. It keeps dropping them until occupancy has drained to a programmable resume level. Program-flow and instrumentation messages keep flowing whenever there is space.
- **Stall policy:** a stall request to the processor is held for as long as the buffer is full.

A message that arrives in the same cycle as a removal from a full buffer always takes the freed slot. This case never triggers any of the policies.

Top module: `trace_msg_fifo`

## Requirements
- R1: After reset the buffer is empty: port_valid_o, overflow_o, suppress_o and stall_o are all 0.
- R2: Accepted messages leave in arrival order with their class and payload unchanged. port_valid_o is 1 exactly when the buffer holds at least one message. The head message is removed in every cycle where port_valid_o and port_ready_i are both 1.
- R3: When a message arrives while the buffer is full and a removal happens in the same cycle, the message is stored. overflow_o does not rise, and suppression does not start.
- R4: Under the halt policy (policy_i = 0, and also 3), a message that arrives while the buffer is full with no removal in that cycle is discarded. In that case overflow_o rises on the next cycle.
- R5: Under the halt policy, every arriving message is ignored while overflow_o is 1, even if there is room. Removal at the output continues.
- R6: overflow_o stays 1 until a one-cycle ovf_clr_i pulse. It is 0 in the cycle after the pulse. A message that arrives in the pulse cycle is ignored, and messages are accepted again from the next cycle.
- R7: Under the suppress policy (policy_i = 1), suppress_o rises in the cycle after the buffer goes from not full to full. While suppress_o is 1, messages with class 1 (data) are discarded.
- R8: While suppress_o is 1, messages with class 0 (program) or class 2 (instrumentation) are still stored whenever there is room.
- R9: Suppression ends when occupancy falls to the resume level. The check uses occupancy after the cycle's removal and storage. When occupancy is at or below resume_lvl_i, suppress_o is 0 in the next cycle. The resume level must be below the depth.
- R10: Under the stall policy (policy_i = 2), stall_o is 1 in every cycle where the buffer is full. It falls in the cycle after a removal leaves a free slot. A message that arrives while the buffer is full with no removal is not stored.
- R11: Only the halt policy raises overflow_o. Only the suppress policy filters data-class messages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Full policy: 0 halt, 1 suppress data, 2 stall, 3 halt |
| resume_lvl_i | input | $clog2(DEPTH+1) | Occupancy at or below which suppression ends |
| ovf_clr_i | input | 1 | One-cycle pulse that clears the overflow flag |
| msg_valid_i | input | 1 | A trace message is offered this cycle |
| msg_kind_i | input | 2 | Message class: 0 program, 1 data, 2 instrumentation |
| msg_data_i | input | DATA_W | Message payload |
| port_ready_i | input | 1 | Output port takes the head message this cycle |
| port_valid_o | output | 1 | A message is available at the output |
| port_kind_o | output | 2 | Class of the head message |
| port_data_o | output | DATA_W | Payload of the head message |
| overflow_o | output | 1 | Sticky flag: tracing halted after a lost message |
| suppress_o | output | 1 | Data-class messages are currently being dropped |
| stall_o | output | 1 | Stall request to the processor |

## Verification
The bench builds two copies from the same stimulus, both with DATA_W = 16.

- **DEPTH = 16:** this is the smallest legal depth, so the buffer fills within a few cycles. All three policies and the full-buffer boundary can therefore be reached often.
- **DEPTH = 24:** this is not a power of two, which selects the explicit pointer-wrap variant. Its pointers wrap many times during the random phase.

Directed sequences cover these cases:

- the pass-through of a message that arrives alongside a removal on a full buffer;
- the halt, clear and resume sequence;
- the suppression hysteresis down to a resume level of 4, with program and instrumentation messages slipping through;
- the stall release.

Random traffic then rotates through all four policy codes and several resume levels, with sporadic clear pulses.

// File: rtl/tmf_pkg.sv
`timescale 1ns/1ps
package tmf_pkg;

   typedef enum logic [1:0] {
      KIND_PROG  = 2'd0,
      KIND_DATA  = 2'd1,
      KIND_INSTR = 2'd2,
      KIND_RSVD  = 2'd3
   } tmf_kind_e;

   typedef enum logic [1:0] {
      POL_HALT     = 2'd0,
      POL_SUPPRESS = 2'd1,
      POL_STALL    = 2'd2,
      POL_RSVD     = 2'd3
   } tmf_policy_e;

   localparam int KIND_W    = 2;
   localparam int MIN_DEPTH = 16;
   localparam int MAX_DEPTH = 64;

endpackage

// File: rtl/tmf_store.sv
`timescale 1ns/1ps
module tmf_store #(
   parameter  int DEPTH   = 16,
   parameter  int ENTRY_W = 34,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               pop,
   input  logic [ENTRY_W-1:0] wr_entry,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic [CNT_W-1:0]   level,
   output logic               full,
   output logic               empty
);

   logic [ENTRY_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [PTR_W-1:0]   wr_nxt, rd_nxt;
   logic [CNT_W-1:0]   cnt_q;

   // pointer advance: free wrap for power-of-two depths, explicit wrap otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && (wr_ptr == PTR_W'(i))) begin
            slot[i] <= wr_entry;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign rd_entry = slot[rd_ptr];
   assign level    = cnt_q;
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign empty    = (cnt_q == '0);

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);

   // R2
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/tmf_policy.sv
`timescale 1ns/1ps
module tmf_policy
   import tmf_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  tmf_policy_e mode,
   input  logic [CNT_W-1:0] resume_lvl,
   input  logic        ovf_clr,
   input  logic        in_valid,
   input  tmf_kind_e   in_kind,
   input  logic        full,
   input  logic [CNT_W-1:0] level,
   input  logic        pop,
   output logic        push,
   output logic        overflow,
   output logic        suppress,
   output logic        stall
);

   logic             halt_mode;
   logic             room;
   logic             blocked;
   logic             ovf_set;
   logic             ovf_q;
   logic             sup_q;
   logic [CNT_W-1:0] lvl_next;

   always_comb begin
      halt_mode = (mode == POL_HALT) || (mode == POL_RSVD);
      room      = !full || pop;
      if (halt_mode) begin
         blocked = ovf_q;
      end else begin
         blocked = (mode == POL_SUPPRESS) && sup_q && (in_kind == KIND_DATA);
      end
      push     = in_valid && !blocked && room;
      ovf_set  = halt_mode && in_valid && !ovf_q && !room;
      lvl_next = level + CNT_W'(push) - CNT_W'(pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end else if (ovf_set) begin
         ovf_q <= 1'b1;
      end
   end

   // suppression hysteresis judged on occupancy after this cycle's pop and push
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_q <= 1'b0;
      end else if (mode != POL_SUPPRESS) begin
         sup_q <= 1'b0;
      end else if (!sup_q) begin
         sup_q <= (lvl_next == CNT_W'(DEPTH)) && !full;
      end else if (lvl_next <= resume_lvl) begin
         sup_q <= 1'b0;
      end
   end

   assign overflow = ovf_q;
   assign suppress = sup_q;
   assign stall    = (mode == POL_STALL) && full;

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clr) |=> overflow);

   // R4
   ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == POL_HALT) && in_valid && full && !pop && !overflow && !ovf_clr) |=> overflow);

   // R7
   sup_rise_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suppress) |-> full);

   // R9
   resume_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == POL_SUPPRESS) |-> (resume_lvl < CNT_W'(DEPTH)));

endmodule

// File: rtl/trace_msg_fifo.sv
`timescale 1ns/1ps
module trace_msg_fifo
   import tmf_pkg::*;
#(
   parameter  int DEPTH  = 16,
   parameter  int DATA_W = 32,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        policy_i,
   input  logic [CNT_W-1:0]  resume_lvl_i,
   input  logic              ovf_clr_i,
   input  logic              msg_valid_i,
   input  logic [1:0]        msg_kind_i,
   input  logic [DATA_W-1:0] msg_data_i,
   input  logic              port_ready_i,
   output logic              port_valid_o,
   output logic [1:0]        port_kind_o,
   output logic [DATA_W-1:0] port_data_o,
   output logic              overflow_o,
   output logic              suppress_o,
   output logic              stall_o
);

   localparam int ENTRY_W = DATA_W + KIND_W;

   generate
      if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH) begin : g_bad_depth
         $error("trace_msg_fifo: DEPTH must lie within 16..64");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("trace_msg_fifo: DATA_W must be positive");
      end
   endgenerate

   logic               q_push, q_pop, q_full, q_empty;
   logic [CNT_W-1:0]   q_level;
   logic [ENTRY_W-1:0] q_head;

   assign q_pop = port_ready_i && !q_empty;

   tmf_store #(
      .DEPTH   (DEPTH),
      .ENTRY_W (ENTRY_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push),
      .pop      (q_pop),
      .wr_entry ({msg_kind_i, msg_data_i}),
      .rd_entry (q_head),
      .level    (q_level),
      .full     (q_full),
      .empty    (q_empty)
   );

   tmf_policy #(
      .DEPTH (DEPTH)
   ) u_policy (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (tmf_policy_e'(policy_i)),
      .resume_lvl (resume_lvl_i),
      .ovf_clr    (ovf_clr_i),
      .in_valid   (msg_valid_i),
      .in_kind    (tmf_kind_e'(msg_kind_i)),
      .full       (q_full),
      .level      (q_level),
      .pop        (q_pop),
      .push       (q_push),
      .overflow   (overflow_o),
      .suppress   (suppress_o),
      .stall      (stall_o)
   );

   assign port_valid_o = !q_empty;
   assign port_kind_o  = q_head[ENTRY_W-1 -: KIND_W];
   assign port_data_o  = q_head[DATA_W-1:0];

   // R5
   halt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((policy_i == 2'd0) && overflow_o && msg_valid_i)
      |=> (q_level == $past(q_level) - CNT_W'($past(q_pop))));

   // R7
   data_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((policy_i == 2'd1) && suppress_o && msg_valid_i && (msg_kind_i == 2'd1))
      |=> (q_level == $past(q_level) - CNT_W'($past(q_pop))));

   // R3
   full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && msg_valid_i && q_pop && !overflow_o && !suppress_o)
      |=> (!overflow_o && !suppress_o && q_full));

   // R10
   stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && q_pop && !msg_valid_i) |=> !stall_o);

   // R9
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(suppress_o) && (policy_i == 2'd1) && $stable(resume_lvl_i))
      |-> (q_level <= resume_lvl_i));

   // R11
   no_ovf_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((policy_i == 2'd1 || policy_i == 2'd2) && !overflow_o) |=> !overflow_o);

endmodule

// File: tb/trace_msg_fifo_tb.sv
`timescale 1ns/1ps
module tmf_ref_model #(
   parameter int DEPTH = 16,
   parameter int DW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    policy,
   input  logic [4:0]    resume,
   input  logic          clr,
   input  logic          valid,
   input  logic [1:0]    kind,
   input  logic [DW-1:0] data,
   input  logic          ready,
   output logic          e_valid,
   output logic [1:0]    e_kind,
   output logic [DW-1:0] e_data,
   output logic          e_ovf,
   output logic          e_sup,
   output logic          e_stall
);
   logic [DW+1:0] q [$];
   bit ovf, sup, is_full;

   always @(posedge clk) begin
      int n, n2;
      bit full_now, do_pop, halt, blocked, room, do_push;
      if (!rst_n) begin
         q.delete();
         ovf = 0;
         sup = 0;
      end else begin
         n        = q.size();
         full_now = (n == DEPTH);
         do_pop   = ready && (n != 0);
         halt     = (policy == 2'd0) || (policy == 2'd3);
         blocked  = halt ? ovf : ((policy == 2'd1) && sup && (kind == 2'd1));
         room     = !full_now || do_pop;
         do_push  = valid && !blocked && room;
         if (clr) ovf = 0;
         else if (halt && valid && !ovf && !room) ovf = 1;
         n2 = n - int'(do_pop) + int'(do_push);
         if (policy != 2'd1) sup = 0;
         else if (!sup) sup = (n2 == DEPTH) && !full_now;
         else if (n2 <= int'(resume)) sup = 0;
         if (do_pop) void'(q.pop_front());
         if (do_push) q.push_back({kind, data});
      end
      is_full = (q.size() == DEPTH);
      e_valid = (q.size() != 0);
      if (q.size() != 0) begin
         e_kind = q[0][DW+1:DW];
         e_data = q[0][DW-1:0];
      end else begin
         e_kind = '0;
         e_data = '0;
      end
      e_ovf = ovf;
      e_sup = sup;
   end

   assign e_stall = (policy == 2'd2) && is_full;
endmodule

module trace_msg_fifo_tb;
   localparam int CLK_P = 10;
   localparam int DW    = 16;
   localparam int WDOG  = 60000;

   logic clk = 1'b0;
   logic rst_n;
   logic [1:0]    pol;
   logic [4:0]    rlv;
   logic          clr, vld, rdy;
   logic [1:0]    knd;
   logic [DW-1:0] dat;

   logic          a_val, a_ovf, a_sup, a_stl;
   logic [1:0]    a_knd;
   logic [DW-1:0] a_dat;
   logic          b_val, b_ovf, b_sup, b_stl;
   logic [1:0]    b_knd;
   logic [DW-1:0] b_dat;

   logic          ea_val, ea_ovf, ea_sup, ea_stl;
   logic [1:0]    ea_knd;
   logic [DW-1:0] ea_dat;
   logic          eb_val, eb_ovf, eb_sup, eb_stl;
   logic [1:0]    eb_knd;
   logic [DW-1:0] eb_dat;

   int checks = 0;
   int errors = 0;
   int wd     = 0;
   bit cmp_on = 0;

   always #(CLK_P/2) clk = ~clk;

   trace_msg_fifo #(.DEPTH(16), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .policy_i(pol), .resume_lvl_i(rlv),
      .ovf_clr_i(clr), .msg_valid_i(vld), .msg_kind_i(knd), .msg_data_i(dat),
      .port_ready_i(rdy), .port_valid_o(a_val), .port_kind_o(a_knd),
      .port_data_o(a_dat), .overflow_o(a_ovf), .suppress_o(a_sup), .stall_o(a_stl));

   trace_msg_fifo #(.DEPTH(24), .DATA_W(DW)) u_dut24 (
      .clk(clk), .rst_n(rst_n), .policy_i(pol), .resume_lvl_i(rlv),
      .ovf_clr_i(clr), .msg_valid_i(vld), .msg_kind_i(knd), .msg_data_i(dat),
      .port_ready_i(rdy), .port_valid_o(b_val), .port_kind_o(b_knd),
      .port_data_o(b_dat), .overflow_o(b_ovf), .suppress_o(b_sup), .stall_o(b_stl));

   tmf_ref_model #(.DEPTH(16), .DW(DW)) u_ref16 (
      .clk(clk), .rst_n(rst_n), .policy(pol), .resume(rlv), .clr(clr),
      .valid(vld), .kind(knd), .data(dat), .ready(rdy),
      .e_valid(ea_val), .e_kind(ea_knd), .e_data(ea_dat),
      .e_ovf(ea_ovf), .e_sup(ea_sup), .e_stall(ea_stl));

   tmf_ref_model #(.DEPTH(24), .DW(DW)) u_ref24 (
      .clk(clk), .rst_n(rst_n), .policy(pol), .resume(rlv), .clr(clr),
      .valid(vld), .kind(knd), .data(dat), .ready(rdy),
      .e_valid(eb_val), .e_kind(eb_knd), .e_data(eb_dat),
      .e_ovf(eb_ovf), .e_sup(eb_sup), .e_stall(eb_stl));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare both copies against their models on every clock
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2 d16 valid", int'(a_val), int'(ea_val));
         if (ea_val) begin
            chk("R2 d16 kind", int'(a_knd), int'(ea_knd));
            chk("R2 d16 data", int'(a_dat), int'(ea_dat));
         end
         chk("R4 d16 overflow", int'(a_ovf), int'(ea_ovf));
         chk("R7 d16 suppress", int'(a_sup), int'(ea_sup));
         chk("R10 d16 stall", int'(a_stl), int'(ea_stl));
         chk("R2 d24 valid", int'(b_val), int'(eb_val));
         if (eb_val) begin
            chk("R2 d24 kind", int'(b_knd), int'(eb_knd));
            chk("R2 d24 data", int'(b_dat), int'(eb_dat));
         end
         chk("R4 d24 overflow", int'(b_ovf), int'(eb_ovf));
         chk("R7 d24 suppress", int'(b_sup), int'(eb_sup));
         chk("R10 d24 stall", int'(b_stl), int'(eb_stl));
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > WDOG) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #(CLK_P/4);
   endtask

   task automatic put(input logic v, input logic [1:0] k, input int d, input logic r);
      vld = v;
      knd = k;
      dat = DW'(d);
      rdy = r;
      tick();
   endtask

   initial begin
      rst_n = 1'b0;
      pol = 2'd0; rlv = 5'd4; clr = 1'b0;
      vld = 1'b0; knd = 2'd0; dat = '0; rdy = 1'b0;
      tick();
      tick();
      cmp_on = 1;
      tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 valid", int'(a_val), 0);
      chk("R1 overflow", int'(a_ovf), 0);
      chk("R1 suppress", int'(a_sup), 0);
      chk("R1 stall", int'(a_stl), 0);

      // halt policy
      for (int i = 0; i < 16; i++) put(1'b1, 2'd0, i, 1'b0);
      chk("R2 head after fill", int'(a_dat), 0);
      chk("R2 valid after fill", int'(a_val), 1);
      put(1'b1, 2'd0, 100, 1'b1);
      chk("R3 overflow on push+pop", int'(a_ovf), 0);
      chk("R2 head advanced", int'(a_dat), 1);
      put(1'b1, 2'd0, 200, 1'b0);
      chk("R4 overflow raised", int'(a_ovf), 1);
      for (int i = 0; i < 16; i++) put(1'b1, 2'd1, 300 + i, 1'b1);
      chk("R5 halted drained empty", int'(a_val), 0);
      chk("R6 overflow sticky", int'(a_ovf), 1);
      clr = 1'b1;
      put(1'b1, 2'd0, 400, 1'b0);
      clr = 1'b0;
      chk("R6 overflow cleared", int'(a_ovf), 0);
      chk("R6 clear-cycle message ignored", int'(a_val), 0);
      put(1'b1, 2'd0, 401, 1'b0);
      chk("R6 accepts after clear", int'(a_dat), 401);
      put(1'b0, 2'd0, 0, 1'b1);

      // suppress policy
      pol = 2'd1;
      for (int i = 0; i < 16; i++) put(1'b1, 2'd0, 500 + i, 1'b0);
      chk("R7 suppress on fill", int'(a_sup), 1);
      put(1'b1, 2'd1, 600, 1'b1);
      chk("R7 suppress held", int'(a_sup), 1);
      chk("R2 head after pop", int'(a_dat), 501);
      put(1'b1, 2'd1, 601, 1'b0);
      put(1'b1, 2'd2, 602, 1'b0);
      for (int i = 0; i < 11; i++) put(1'b0, 2'd0, 0, 1'b1);
      chk("R9 suppress above level", int'(a_sup), 1);
      put(1'b0, 2'd0, 0, 1'b1);
      chk("R9 suppress released", int'(a_sup), 0);
      chk("R9 head at release", int'(a_dat), 513);
      for (int i = 0; i < 3; i++) put(1'b0, 2'd0, 0, 1'b1);
      chk("R8 instrumentation kept", int'(a_dat), 602);
      chk("R8 instrumentation kind", int'(a_knd), 2);
      put(1'b0, 2'd0, 0, 1'b1);
      chk("R7 data messages dropped", int'(a_val), 0);

      // stall policy
      pol = 2'd2;
      for (int i = 0; i < 16; i++) put(1'b1, 2'd1, 700 + i, 1'b0);
      chk("R10 stall when full", int'(a_stl), 1);
      chk("R11 no suppress in stall", int'(a_sup), 0);
      chk("R11 data stored in stall", int'(a_knd), 1);
      put(1'b1, 2'd0, 999, 1'b0);
      chk("R11 no overflow in stall", int'(a_ovf), 0);
      chk("R10 stall held", int'(a_stl), 1);
      put(1'b0, 2'd0, 0, 1'b1);
      chk("R10 stall released", int'(a_stl), 0);
      chk("R10 head after release", int'(a_dat), 701);
      for (int i = 0; i < 15; i++) put(1'b0, 2'd0, 0, 1'b1);
      chk("R10 message lost while full", int'(a_val), 0);

      // random traffic across all policy codes
      for (int blk = 0; blk < 12; blk++) begin
         pol = 2'(blk % 4);
         rlv = 5'((blk * 3) % 16);
         for (int c = 0; c < 250; c++) begin
            clr = (($urandom % 40) == 0);
            put(($urandom % 3) != 0, 2'($urandom % 3), int'($urandom & 16'hffff),
                ($urandom % 4) < (1 + blk % 3));
         end
      end
      clr = 1'b0;
      put(1'b0, 2'd0, 0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule